// File: doc/BRIEF.md
# Prescaled serial baud generator

This block derives the bit-rate timing of a synchronous serial channel from a base clock. The base clock first passes through an 8-bit time-constant divider. The divider's wrap pulses then feed a power-of-two prescaler. The total divisor is D = N * 2^E. N is the programmed time constant, where a stored zero stands for 256. E is the prescale exponent, and it is never larger than 9. The rates therefore run from the full base clock (N = 1, E = 0) down to the base clock divided by 131072 (N = 256, E = 9).

Software programs the block through a small write port with two registers, selected by `wr_sel`. A written value only goes into a pending copy. The counters adopt pending values only at the end of the period in progress, so a rate change never produces a truncated or stretched bit. The block has two outputs. `rate_tick` is a one-cycle strobe per output period. `bit_clk` is a square wave that is low in the first half of each period and high in the second half.

Top module: `serial_baud_gen`

## Requirements
- R1: For a time constant N in 1..255 and exponent E in 0..9, `rate_tick` repeats every N * 2^E base-clock cycles.
- R2: A stored time constant of zero divides by 256, so N = 0 with E = 9 gives a period of 131072 cycles, the lowest rate.
- R3: An exponent write with a value above 9 is stored as 9.
- R4: `wr_sel` = 0 writes the time constant from all 8 bits of `wr_data`. `wr_sel` = 1 writes the exponent from `wr_data[3:0]`, and `wr_data[7:4]` has no effect.
- R5: `rate_tick` is high for exactly one cycle per period: the last cycle of each period. With N = 1 and E = 0 it is high in every cycle.
- R6: `bit_clk` is low for the first floor(D/2) cycles of each period and high for the rest. An even D therefore gives equal low and high halves.
- R7: A write never alters the period in progress. New values govern the period that begins after the next `rate_tick`, including a write made in the `rate_tick` cycle itself.
- R8: A synchronous reset (`rst_n` low at a clock edge) loads N = 1 and E = 0 as both pending and active settings, and starts a new period. In the first cycle after reset, `rate_tick` and `bit_clk` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 time constant, 1 exponent |
| wr_data | input | 8 | Write data |
| rate_tick | output | 1 | One-cycle strobe in the last cycle of each period |
| bit_clk | output | 1 | Square-wave bit clock |

## Verification
The hardest case to reach from the ports is a write that lands at a precise position within a running period. Examples are a write several cycles after a strobe, and a write in the strobe cycle itself. The stimulus first finds a strobe by sampling `rate_tick`. It then counts cycles from there and asserts `wr_en` in the chosen cycle. Finally, it measures the length of the period in progress and of the one that follows. The deepest setting, 131072 cycles, is measured once as a whole period at the end of the run.

// File: rtl/sbg_pkg.sv
// Package: shared definitions for the prescaled baud generator.
// Assumes: a single write select bit chooses between the two registers.
package sbg_pkg;

    // Register select codes on the write port
    typedef enum logic {
        SEL_TC  = 1'b0,
        SEL_EXP = 1'b1
    } sbg_sel_e;

endpackage

// File: rtl/sbg_cfg_regs.sv
// Module: sbg_cfg_regs
// Holds pending and active copies of the time constant and exponent.
// Writes update the pending copy (exponent clamped to EXP_MAX). The active
// copy loads from the pending value, including a same-cycle write, only
// when period_end is high.
// Assumes: TC_W >= EXP_W; period_end comes from the counter stages.
module sbg_cfg_regs
    import sbg_pkg::*;
#(
    parameter int TC_W    = 8,
    parameter int EXP_W   = 4,
    parameter int EXP_MAX = 9,
    parameter int RST_TC  = 1,
    parameter int RST_EXP = 0,
    localparam int DIV_W  = TC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [TC_W-1:0]  wr_data,
    input  logic             period_end,
    output logic [DIV_W-1:0] act_div,
    output logic [EXP_W-1:0] act_exp
);

    localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(EXP_MAX);
    localparam logic [DIV_W-1:0] DIV_FULL = DIV_W'(1 << TC_W);

    logic [TC_W-1:0]  pend_tc, pend_tc_nx, act_tc;
    logic [EXP_W-1:0] pend_exp, pend_exp_nx;
    logic [EXP_W-1:0] raw_exp;

    assign raw_exp = wr_data[EXP_W-1:0];

    // Next pending values: apply a write, clamping the exponent
    always_comb begin
        pend_tc_nx  = pend_tc;
        pend_exp_nx = pend_exp;
        if (wr_en) begin
            if (wr_sel == SEL_EXP)
                pend_exp_nx = (raw_exp > EXP_CAP) ? EXP_CAP : raw_exp;
            else
                pend_tc_nx = wr_data;
        end
    end

    // Pending registers follow writes; active copy reloads at period end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tc  <= TC_W'(RST_TC);
            pend_exp <= EXP_W'(RST_EXP);
            act_tc   <= TC_W'(RST_TC);
            act_exp  <= EXP_W'(RST_EXP);
        end else begin
            pend_tc  <= pend_tc_nx;
            pend_exp <= pend_exp_nx;
            if (period_end) begin
                act_tc  <= pend_tc_nx;
                act_exp <= pend_exp_nx;
            end
        end
    end

    // Divisor decode: a stored zero means the full 2^TC_W count
    assign act_div = (act_tc == '0) ? DIV_FULL : {1'b0, act_tc};

    // R3
    exp_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_exp <= EXP_CAP);

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> ($stable(act_div) && $stable(act_exp)));

endmodule

// File: rtl/sbg_tc_stage.sv
// Module: sbg_tc_stage
// First divider stage: counts 0..div-1 and wraps. Flags the last count
// and whether the count lies in the upper half (count >= div/2).
// Assumes: div only changes in a cycle where wrap is high.
module sbg_tc_stage #(
    parameter int TC_W   = 8,
    localparam int DIV_W = TC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             wrap,
    output logic             upper
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;

    // Terminal count and half-period decode
    assign wrap  = (cnt == (div - ONE));
    assign upper = (cnt >= (div >> 1));

    // Free-running count that returns to zero after the terminal value
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else
            cnt <= cnt + ONE;
    end

    // R1
    tc_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < div);

endmodule

// File: rtl/sbg_pre_stage.sv
// Module: sbg_pre_stage
// Second divider stage: counts wrap pulses of the first stage modulo 2^exp.
// Flags its last count. Reports the upper half of the full period, taken
// from its own top bit when exp > 0 and from the first stage otherwise.
// Assumes: exp <= EXP_MAX and exp changes only at a period end.
module sbg_pre_stage #(
    parameter int EXP_W   = 4,
    parameter int EXP_MAX = 9,
    localparam int PRE_W  = (EXP_MAX > 0) ? EXP_MAX : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [EXP_W-1:0] exp_sel,
    input  logic             low_upper,
    output logic             last,
    output logic             upper
);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] half_mask;

    // Highest count for this exponent, and its top set bit
    always_comb begin
        limit     = PRE_W'((32'd1 << exp_sel) - 32'd1);
        half_mask = limit ^ (limit >> 1);
    end

    assign last = (cnt == limit);

    // Upper-half decode of the whole period
    assign upper = (exp_sel == '0) ? low_upper : (|(cnt & half_mask));

    // Advance once per first-stage wrap; clear at the end of the period
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step) begin
            if (last)
                cnt <= '0;
            else
                cnt <= cnt + PRE_W'(1);
        end
    end

    // R1
    pre_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit);

endmodule

// File: rtl/serial_baud_gen.sv
// Module: serial_baud_gen (top)
// Divides the base clock by N * 2^E: N is the time constant (0 means
// 2^TC_W), and E is the clamped prescale exponent. Drives a one-cycle
// strobe in the last cycle of each period and a square wave that is high
// in the second half of each period.
// Assumes: a single clock domain; register writes are synchronous to clk.
module serial_baud_gen
    import sbg_pkg::*;
#(
    parameter int TC_W    = 8,
    parameter int EXP_W   = 4,
    parameter int EXP_MAX = 9,
    parameter int RST_TC  = 1,
    parameter int RST_EXP = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [TC_W-1:0] wr_data,
    output logic            rate_tick,
    output logic            bit_clk
);

    localparam int DIV_W = TC_W + 1;

    logic [DIV_W-1:0] act_div;
    logic [EXP_W-1:0] act_exp;
    logic             tc_wrap;
    logic             tc_upper;
    logic             pre_last;
    logic             pre_upper;

    sbg_cfg_regs #(
        .TC_W    (TC_W),
        .EXP_W   (EXP_W),
        .EXP_MAX (EXP_MAX),
        .RST_TC  (RST_TC),
        .RST_EXP (RST_EXP)
    ) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .period_end (rate_tick),
        .act_div    (act_div),
        .act_exp    (act_exp)
    );

    sbg_tc_stage #(
        .TC_W (TC_W)
    ) tc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (act_div),
        .wrap  (tc_wrap),
        .upper (tc_upper)
    );

    sbg_pre_stage #(
        .EXP_W   (EXP_W),
        .EXP_MAX (EXP_MAX)
    ) pre_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (tc_wrap),
        .exp_sel   (act_exp),
        .low_upper (tc_upper),
        .last      (pre_last),
        .upper     (pre_upper)
    );

    // Period ends when both stages sit at their terminal counts
    assign rate_tick = tc_wrap & pre_last;
    assign bit_clk   = pre_upper;

    // R6
    bclk_period_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_tick |=> (bit_clk == ((act_div == DIV_W'(1)) && (act_exp == '0))));

endmodule

// File: tb/serial_baud_gen_tb.sv
`timescale 1ns/1ps
module serial_baud_gen_tb_top;

    localparam int NV = 11;
    localparam logic [7:0] V_TC  [NV] = '{8'd2, 8'd3, 8'd4, 8'd5, 8'd7, 8'd0,
                                         8'd255, 8'd1, 8'd10, 8'd6, 8'd1};
    localparam logic [7:0] V_EXP [NV] = '{8'h00, 8'h00, 8'h01, 8'h02, 8'h03, 8'h00,
                                         8'h01, 8'h09, 8'h0C, 8'hF3, 8'h00};
    localparam int V_PER [NV] = '{2, 3, 8, 20, 56, 256, 510, 512, 5120, 48, 1};
    localparam int V_HI  [NV] = '{1, 2, 4, 10, 28, 128, 255, 256, 2560, 24, 1};
    localparam string V_REQ [NV] = '{"R1/R6", "R1/R6", "R1/R6", "R1/R6", "R1/R6",
                                     "R2", "R1/R6", "R1/R6", "R3", "R4", "R5"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rate_tick;
    logic       bit_clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    serial_baud_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rate_tick (rate_tick),
        .bit_clk   (bit_clk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Find a strobe, then count one whole period and its high cycles
    task automatic measure(output int per, output int hi);
        do @(negedge clk); while (!rate_tick);
        per = 0; hi = 0;
        do begin
            @(negedge clk);
            per++;
            hi += int'(bit_clk);
        end while (!rate_tick);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 195000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int per, hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset settings N=1, E=0 give a strobe and high bit clock at once
        chk(rate_tick == 1'b1, "R8 tick after reset", int'(rate_tick), 1);
        chk(bit_clk == 1'b1, "R8 bit_clk after reset", int'(bit_clk), 1);

        // Table of settings walked by one loop
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, V_TC[i]);
            wr(1'b1, V_EXP[i]);
            measure(per, hi);
            chk(per == V_PER[i], {V_REQ[i], " period"}, per, V_PER[i]);
            chk(hi == V_HI[i], {V_REQ[i], " high count"}, hi, V_HI[i]);
        end

        // R7: a write in the middle of a period leaves that period intact
        wr(1'b0, 8'd100);
        measure(per, hi);
        chk(per == 100, "R7 setup period", per, 100);
        do @(negedge clk); while (!rate_tick);
        per = 0;
        do begin
            @(negedge clk);
            per++;
            if (per == 10) begin wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'd4; end
            if (per == 11) wr_en = 1'b0;
        end while (!rate_tick);
        chk(per == 100, "R7 period in progress", per, 100);
        per = 0;
        do begin @(negedge clk); per++; end while (!rate_tick);
        chk(per == 4, "R7 following period", per, 4);

        // R7: a write in the strobe cycle governs the very next period
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'd9;
        per = 0;
        do begin @(negedge clk); wr_en = 1'b0; per++; end while (!rate_tick);
        chk(per == 9, "R7 write in strobe cycle", per, 9);

        // R8: a reset in mid-run restores the fastest setting
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rate_tick == 1'b1, "R8 tick after mid-run reset", int'(rate_tick), 1);
        chk(bit_clk == 1'b1, "R8 bit_clk after mid-run reset", int'(bit_clk), 1);

        // R2: lowest rate, N=0 (256) with E=9
        wr(1'b0, 8'd0);
        wr(1'b1, 8'd9);
        measure(per, hi);
        chk(per == 131072, "R2 lowest rate period", per, 131072);
        chk(hi == 65536, "R2 lowest rate high count", hi, 65536);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule